// File: doc/BRIEF.md
# Manchester Line Transceiver with Collision Detection

This block sits between a serial frame controller and a line driver/receiver pair. From one master clock (16 MHz nominal) it derives a system clock at one quarter of that rate and a transmit bit clock whose cell is 16 or 32 master clocks long. The cell length is picked by a select input. While request-to-send (active low) is asserted, serial transmit data is phase-encoded onto the line output. With request-to-send released, the line rests high.

In the other direction, the incoming phase-encoded line is synchronised to the master clock. The decoder locks onto the mid-cell transitions and delivers recovered data with a matching receive clock. While transmitting, the block reads the line back once per cell and raises a sticky collision flag when the line disagrees with what was sent.

Top module: `manch_link_xcvr`

## Requirements
- R1: `sys_clk` is the master clock divided by 4 with 50% duty. It is low during reset and toggles on every second master clock edge after reset.
- R2: A cell counter starts at 0 when reset is released. `rate_sel`=0 selects a cell of P=16 master clocks and `rate_sel`=1 selects P=32. `tx_bit_clk` is high in the first P/2 clocks of each cell and low in the last P/2.
- R3: `tx_data` is captured on the edge that starts a cell (phase 0). `line_out` is registered. After the edge at phase p it carries the captured bit for p < P/2 and the inverse of that bit for p >= P/2. So a 1 is sent high-then-low, a 0 is sent low-then-high, and every cell has a transition at mid-cell.
- R4: Transmission begins only on a phase-0 edge that sees `rts_n`=0. On any edge that sees `rts_n`=1, `line_out` goes to 1 and encoding stops. Lowering `rts_n` mid-cell leaves the line high until the next cell start.
- R5: The decoder treats a line transition as mid-cell when at least 3P/4 master clocks have passed since the last accepted one. The first transition after idle is always accepted. On acceptance, `rx_data` takes the line level from before the transition (1 for falling, 0 for rising).
- R6: Line transitions that come less than 3P/4 clocks after the last accepted one, such as cell-boundary transitions or short glitches, change neither `rx_data` nor the bit phase.
- R7: `rx_clk` rests high. It falls on the edge where `rx_data` updates and rises exactly P/2 master clocks later. `rx_data` changes only together with a falling `rx_clk`.
- R8: On the phase 3P/4 edge of a transmitted cell, `line_in` is compared with the expected second-half level (the inverse of the sent bit). A mismatch sets `collision`. A clean loopback never sets it.
- R9: `collision` stays set while `rts_n` stays low. It is cleared by the first edge that sees `rts_n`=1.
- R10: During reset, `line_out`=1, `collision`=0, `rx_clk`=1, `rx_data`=1 and `sys_clk`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 1 | Cell length select: 0 = 16 clocks, 1 = 32 clocks |
| tx_data | input | 1 | Serial data to send |
| rts_n | input | 1 | Request-to-send, active low |
| line_in | input | 1 | Phase-encoded line from the receiver |
| sys_clk | output | 1 | Master clock divided by 4 |
| tx_bit_clk | output | 1 | Transmit bit clock, high in the first half of each cell |
| line_out | output | 1 | Phase-encoded line to the driver |
| rx_data | output | 1 | Recovered receive data |
| rx_clk | output | 1 | Recovered receive clock |
| collision | output | 1 | Sticky mismatch between sent and observed line |

## Verification
The bench loops the line output back into the decoder at both cell lengths. It uses patterns that include long runs of ones and zeros, where a decoder that locks onto boundary transitions would lose bit phase and return shifted or inverted data. A single-clock flip is forced on the line at the three-quarter point of one cell. This must raise the sticky flag and must not disturb decoding: a comparator sampling at the wrong phase misses the flip, and a decoder with too short a blanking window slips a bit. The bench also lowers request-to-send mid-cell and raises it mid-cell, to catch an encoder that starts off the cell boundary or keeps driving after release. It also checks the receive clock spacing, so a clock that rises at the wrong point or that lets data move around its edge is flagged.

// File: rtl/manch_link_pkg.sv
package manch_link_pkg;
   typedef enum logic {
      RATE_DIV_LO = 1'b0,
      RATE_DIV_HI = 1'b1
   } rate_e;
endpackage

// File: rtl/manch_clkgen.sv
module manch_clkgen
   import manch_link_pkg::*;
#(
   parameter int FAST_LOG2 = 4,
   parameter int SLOW_LOG2 = 5,
   parameter int SYS_LOG2  = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rate_sel,
   output logic [SLOW_LOG2-1:0] phase_o,
   output logic [SLOW_LOG2-1:0] half_o,
   output logic [SLOW_LOG2-1:0] q3_o,
   output logic                 sys_clk,
   output logic                 tx_bit_clk
);
   localparam int CW = SLOW_LOG2;
   localparam logic [CW-1:0] ONE       = CW'(1);
   localparam logic [CW-1:0] FAST_MASK = CW'((1 << FAST_LOG2) - 1);
   localparam logic [CW-1:0] HALF_F    = CW'(1 << (FAST_LOG2 - 1));
   localparam logic [CW-1:0] HALF_S    = CW'(1 << (SLOW_LOG2 - 1));
   localparam logic [CW-1:0] Q3_F      = CW'(3 << (FAST_LOG2 - 2));
   localparam logic [CW-1:0] Q3_S      = CW'(3 << (SLOW_LOG2 - 2));

   generate
      if (FAST_LOG2 < 3) begin : g_bad_fast
         initial $fatal(1, "manch_clkgen: FAST_LOG2 must be at least 3");
      end
      if (SLOW_LOG2 <= FAST_LOG2) begin : g_bad_slow
         initial $fatal(1, "manch_clkgen: SLOW_LOG2 must exceed FAST_LOG2");
      end
      if (SYS_LOG2 < 1 || SYS_LOG2 > FAST_LOG2) begin : g_bad_sys
         initial $fatal(1, "manch_clkgen: SYS_LOG2 out of range");
      end
   endgenerate

   logic [CW-1:0] cnt;
   rate_e         rate;

   assign rate = rate_e'(rate_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + ONE;
   end

   assign phase_o    = (rate == RATE_DIV_HI) ? cnt : (cnt & FAST_MASK);
   assign half_o     = (rate == RATE_DIV_HI) ? HALF_S : HALF_F;
   assign q3_o       = (rate == RATE_DIV_HI) ? Q3_S : Q3_F;
   assign sys_clk    = cnt[SYS_LOG2-1];
   assign tx_bit_clk = (phase_o < half_o);

   // R1: after any change the system clock holds for one more cycle
   p_sys_half_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_clk != $past(sys_clk)) |=> $stable(sys_clk));
endmodule

// File: rtl/manch_tx.sv
module manch_tx #(
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] phase,
   input  logic [PW-1:0] half,
   input  logic [PW-1:0] q3,
   input  logic          tx_data,
   input  logic          rts_n,
   input  logic          line_in,
   output logic          line_out,
   output logic          collision
);
   logic tx_on;
   logic bit_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_on    <= 1'b0;
         bit_r    <= 1'b0;
         line_out <= 1'b1;
      end else if (phase == '0) begin
         tx_on    <= !rts_n;
         bit_r    <= tx_data;
         line_out <= rts_n | tx_data;
      end else if (rts_n) begin
         tx_on    <= 1'b0;
         line_out <= 1'b1;
      end else if (tx_on) begin
         line_out <= (phase < half) ? bit_r : !bit_r;
      end else begin
         line_out <= 1'b1;
      end
   end

   // comparator: second half should carry the inverse of the sent bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      collision <= 1'b0;
      else if (rts_n)                                  collision <= 1'b0;
      else if (tx_on && phase == q3 && line_in == bit_r) collision <= 1'b1;
   end

   // R4: released request-to-send leaves the line high
   p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rts_n) |-> line_out);
   // R3: every transmitted cell toggles the line at mid-cell
   p_mid_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_on && !rts_n && phase == half) |=> (line_out != $past(line_out)));
   // R9: flag holds while request-to-send stays low
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (collision && !rts_n) |=> collision);
   // R9: flag clears once request-to-send is released
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rts_n |=> !collision);
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
   parameter int PW   = 5,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] half,
   input  logic [PW-1:0] q3,
   input  logic          line_in,
   output logic          rx_data,
   output logic          rx_clk
);
   localparam int GW = PW + 2;
   localparam logic [GW-1:0] ONE = GW'(1);

   logic          s;
   logic          lvl;
   logic [GW-1:0] gap;
   logic          edge_seen;
   logic          accept;

   generate
      if (SYNC < 1) begin : g_bad_sync
         initial $fatal(1, "manch_rx: SYNC must be at least 1");
      end else if (SYNC == 1) begin : g_sync1
         logic sreg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sreg <= 1'b1;
            else        sreg <= line_in;
         end
         assign s = sreg;
      end else begin : g_syncn
         logic [SYNC-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[SYNC-2:0], line_in};
         end
         assign s = sr[SYNC-1];
      end
   endgenerate

   assign edge_seen = s ^ lvl;
   assign accept    = edge_seen && (gap >= {2'b00, q3});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl     <= 1'b1;
         gap     <= '1;
         rx_data <= 1'b1;
         rx_clk  <= 1'b1;
      end else begin
         lvl <= s;
         if (accept) begin
            gap     <= '0;
            rx_data <= lvl;
            rx_clk  <= 1'b0;
         end else begin
            if (gap != '1) gap <= gap + ONE;
            if (gap == {2'b00, half} - ONE) rx_clk <= 1'b1;
         end
      end
   end

   // R6: a blanked transition leaves the recovered data alone
   p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_seen && gap < {2'b00, q3}) |=> $stable(rx_data));
   // R7: data moves only while the receive clock is low
   p_fall_on_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_data != $past(rx_data)) |-> !rx_clk);
endmodule

// File: rtl/manch_link_xcvr.sv
module manch_link_xcvr #(
   parameter int FAST_LOG2   = 4,
   parameter int SLOW_LOG2   = 5,
   parameter int SYS_LOG2    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_sel,
   input  logic tx_data,
   input  logic rts_n,
   input  logic line_in,
   output logic sys_clk,
   output logic tx_bit_clk,
   output logic line_out,
   output logic rx_data,
   output logic rx_clk,
   output logic collision
);
   localparam int PW = SLOW_LOG2;

   logic [PW-1:0] phase;
   logic [PW-1:0] half;
   logic [PW-1:0] q3;

   manch_clkgen #(
      .FAST_LOG2(FAST_LOG2),
      .SLOW_LOG2(SLOW_LOG2),
      .SYS_LOG2 (SYS_LOG2)
   ) clkgen_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rate_sel  (rate_sel),
      .phase_o   (phase),
      .half_o    (half),
      .q3_o      (q3),
      .sys_clk   (sys_clk),
      .tx_bit_clk(tx_bit_clk)
   );

   manch_tx #(.PW(PW)) tx_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .half     (half),
      .q3       (q3),
      .tx_data  (tx_data),
      .rts_n    (rts_n),
      .line_in  (line_in),
      .line_out (line_out),
      .collision(collision)
   );

   manch_rx #(.PW(PW), .SYNC(SYNC_STAGES)) rx_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .half   (half),
      .q3     (q3),
      .line_in(line_in),
      .rx_data(rx_data),
      .rx_clk (rx_clk)
   );
endmodule

// File: tb/manch_link_xcvr_tb_top.sv
module manch_link_xcvr_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rate_sel = 1'b0;
   logic tx_data = 1'b0;
   logic rts_n = 1'b1;
   logic flip = 1'b0;
   logic sys_clk, tx_bit_clk, line_out, rx_data, rx_clk, collision;
   wire  line_lb = line_out ^ flip;

   manch_link_xcvr dut_i (
      .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tx_data(tx_data),
      .rts_n(rts_n), .line_in(line_lb), .sys_clk(sys_clk),
      .tx_bit_clk(tx_bit_clk), .line_out(line_out), .rx_data(rx_data),
      .rx_clk(rx_clk), .collision(collision)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // behavioural reference of the transmit side (R2, R3, R4, R8, R9)
   int m_cnt = 0;
   int mp, mph;
   bit e_on = 0, e_bit = 0, e_line = 1, e_col = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; e_on = 0; e_bit = 0; e_line = 1; e_col = 0;
      end else begin
         mp  = rate_sel ? 32 : 16;
         mph = m_cnt % mp;
         if (rts_n) e_col = 0;
         else if (e_on && mph == 3 * mp / 4 && line_lb != !e_bit) e_col = 1;
         if (mph == 0) begin
            e_on = !rts_n; e_bit = tx_data; e_line = rts_n ? 1'b1 : tx_data;
         end else if (rts_n) begin
            e_on = 0; e_line = 1;
         end else if (e_on) begin
            e_line = (mph < mp / 2) ? e_bit : !e_bit;
         end else begin
            e_line = 1;
         end
         m_cnt++;
      end
   end

   // receive side expectations
   bit    rx_q[$];
   bit    rx_en = 0;
   string rx_tag = "R5";
   bit    prev_rxclk = 1, prev_rxd = 1;
   int    since_fall = 0;
   int    cp;
   bit    fell;

   always @(negedge clk) begin
      if (!rst_n) begin
         check("R10 reset line_out", line_out, 1);
         check("R10 reset collision", collision, 0);
         check("R10 reset rx_clk", rx_clk, 1);
         check("R10 reset rx_data", rx_data, 1);
         check("R10 reset sys_clk", sys_clk, 0);
      end else begin
         cp = rate_sel ? 32 : 16;
         check("R1 sys_clk", sys_clk, (m_cnt / 2) % 2);
         check("R2 tx_bit_clk", tx_bit_clk, ((m_cnt % cp) < cp / 2) ? 1 : 0);
         check("R3 line_out", line_out, e_line);
         check("R8 collision", collision, e_col);
         fell = prev_rxclk && !rx_clk;
         since_fall++;
         if (fell) since_fall = 0;
         check("R7 rx_data moves only with rx_clk fall",
               ((rx_data != prev_rxd) && !fell) ? 1 : 0, 0);
         if (!prev_rxclk && rx_clk) begin
            check("R7 rx_clk rise spacing", since_fall, cp / 2);
            if (rx_en) begin
               if (rx_q.size() == 0) check({rx_tag, " extra decoded bit"}, 1, 0);
               else check({rx_tag, " decoded bit"}, rx_data, rx_q.pop_front());
            end
         end
      end
      prev_rxclk = rx_clk;
      prev_rxd   = rx_data;
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic run_frame(input int nbits, input logic [63:0] pat, input bit rate,
                            input int flip_cell, input bit early, input bit abort,
                            input bit en_rx, input string tag);
      int p;
      p = rate ? 32 : 16;
      rate_sel = rate;
      repeat (120) step();
      rx_q.delete();
      rx_en  = en_rx;
      rx_tag = tag;
      if (early) begin
         while ((m_cnt % p) != p / 2) step();
         rts_n = 0; tx_data = 0;
         repeat (p / 2 - 1) step();
         check("R4 no start mid-cell", line_out, 1);
         step();
      end else begin
         while ((m_cnt % p) != 0) step();
      end
      for (int i = 0; i < nbits; i++) begin
         rts_n = 0;
         tx_data = pat[i];
         if (en_rx) rx_q.push_back(pat[i]);
         for (int k = 0; k < p; k++) begin
            flip = (i == flip_cell && k == 3 * p / 4);
            if (flip_cell >= 0 && i == flip_cell + 1 && k == 0)
               check("R8 collision raised", collision, 1);
            if (flip_cell >= 0 && i == nbits - 1 && k == p - 1)
               check("R9 collision held", collision, 1);
            if (flip_cell < 0 && !abort && i == nbits - 1 && k == p - 1)
               check("R8 no false collision", collision, 0);
            if (abort && i == nbits - 1 && k == p / 4) rts_n = 1;
            if (abort && i == nbits - 1 && k == p / 4 + 2)
               check("R4 line idles after stop", line_out, 1);
            step();
         end
      end
      rts_n = 1;
      flip  = 0;
      repeat (2) step();
      check("R9 collision cleared", collision, 0);
      check("R4 idle line high", line_out, 1);
      repeat (3 * p) step();
      if (en_rx) check({tag, " all bits decoded"}, rx_q.size(), 0);
      rx_en = 0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1 rst_n = 1;
      run_frame(24, 64'h0000_0000_00C3_5A97, 1'b0, -1, 1'b0, 1'b0, 1'b1, "R5");
      run_frame(32, 64'h0000_0000_F0E1_36C9, 1'b1, -1, 1'b0, 1'b0, 1'b1, "R5");
      run_frame(28, 64'h0000_0000_00FF_00F1, 1'b0, -1, 1'b0, 1'b0, 1'b1, "R5");
      run_frame(20, 64'h0000_0000_0009_B2E5, 1'b1,  8, 1'b0, 1'b0, 1'b1, "R6");
      run_frame(16, 64'h0000_0000_0000_7A33, 1'b0,  3, 1'b0, 1'b0, 1'b1, "R6");
      run_frame(10, 64'h0000_0000_0000_0155, 1'b0, -1, 1'b1, 1'b1, 1'b0, "R4");
      repeat (20) step();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule